// File: doc/BRIEF.md
# Power-Up Reset Timeout Sequencer

This block decides when the internal reset of a small microcontroller core may be released after the supply comes up. It watches a power-on pulse, a brown-out detect level, an active-low external master reset pin and a watchdog reset request. Once the power-on pulse has ended it runs two timeout stages one after the other. The first is a power-up timer counted in ticks of a slow clock-enable. The second is an oscillator start-up counter counted in cycles of the main clock. Either stage is skipped depending on the oscillator-mode setting and an active-low timer enable bit. After the last stage the core reset is released.

The external pin does not hold the stages back. They keep running while the pin is low, so raising the pin after they expire starts the core on the next clock. Watchdog and pin resets only hold the core in reset and never rerun the timeouts. A two-bit reset-cause register records power-on and brown-out events. Software can write it to arm the flags for the next reset.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `rst` is high, the block enters state 0 (`state_o` = 2'b00), drives `core_rst_o` = 1 and clears `cause_o` to 2'b00.
- R2: `state_o` encodes 0 = waiting for power-on end, 1 = power-up timer, 2 = oscillator start-up, 3 = running. `core_rst_o` is 1 whenever `state_o` is not 3.
- R3: While `por_i` is high the state stays 0. The sequence leaves state 0 on the first clock edge at which `por_i` is low.
- R4: The power-up timer (state 1) runs only when `pwrt_dis_i` = 0. It ends on the clock edge that samples the `PWRT_TICKS`-th high `slow_tick_i` since it began. When `pwrt_dis_i` = 1 the stage is skipped.
- R5: The oscillator start-up stage (state 2) follows the power-up timer, or follows state 0 when the timer is skipped. It lasts exactly `OST_CYCLES` clocks. It runs only for crystal modes `osc_mode_i` = 3'b000, 3'b001 and 3'b010, and is skipped for modes 3'b011 to 3'b111.
- R6: With `osc_mode_i` = 3'b011 (external clock) and `pwrt_dis_i` = 1, the state is 3 and `core_rst_o` is 0 one clock edge after `por_i` goes low.
- R7: `mclr_n_i` low holds `core_rst_o` at 1 but does not stop or restart the stages. When the pin rises with state 3, `core_rst_o` falls on the next clock edge.
- R8: A `wdt_rst_i` high sampled at an edge forces `core_rst_o` = 1 for the following cycle. It leaves the state unchanged (no rerun of the timeouts).
- R9: `por_i` high, or `bor_i` high while `bor_en_i` != 2'b00, returns the state to 0 on the next edge from any state. `bor_i` has no effect while `bor_en_i` = 2'b00.
- R10: `cause_o[1]` (power-on flag) is cleared by `por_i`. It is loaded from `sw_wdata_i[1]` on a write (`sw_wr_i`). Watchdog and pin resets leave it unchanged.
- R11: `cause_o[0]` (brown-out flag) is cleared by an enabled brown-out and is unchanged by a power-on. It is loaded from `sw_wdata_i[0]` on a write. A clearing event in the same cycle as a write takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high register initialisation |
| por_i | input | 1 | Power-on pulse, high while the pulse lasts |
| bor_i | input | 1 | Brown-out detect level |
| bor_en_i | input | 2 | Brown-out enable field; 2'b00 disables |
| mclr_n_i | input | 1 | External master reset pin, active low |
| wdt_rst_i | input | 1 | Watchdog reset request |
| osc_mode_i | input | 3 | Oscillator mode setting |
| pwrt_dis_i | input | 1 | Power-up timer enable, active low (1 skips the timer) |
| slow_tick_i | input | 1 | Slow clock-enable that paces the power-up timer |
| sw_wr_i | input | 1 | Software write strobe for the cause register |
| sw_wdata_i | input | 2 | Software write data: bit 1 power-on flag, bit 0 brown-out flag |
| state_o | output | 2 | Sequencer state |
| core_rst_o | output | 1 | Reset to the core, active high |
| cause_o | output | 2 | Reset-cause flags: bit 1 power-on, bit 0 brown-out |

## Verification
Every output is a register, so a stimulus sampled at an edge shows on `state_o`, `core_rst_o` and `cause_o` just after that same edge. The bench drives and samples 1 ns after each rising edge.

In the sweep, edges are numbered from the release of `por_i`. The release edge is 1 when the timer is skipped, or `PWRT_TICKS` x tick spacing when it runs. `OST_CYCLES` is added for crystal modes. The bench compares the state on that edge and on the edge just before it.

Watchdog, pin and software-write effects are checked one edge after the stimulus. The watchdog hold is checked again one edge later to confirm it clears.

// File: rtl/pwrup_rst_pkg.sv
package pwrup_rst_pkg;

  typedef enum logic [1:0] {
    ST_POR  = 2'd0,
    ST_PWRT = 2'd1,
    ST_OST  = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;

  localparam int OSC_MODE_W = 3;

  // Crystal and resonator modes occupy the three lowest codes.
  localparam logic [OSC_MODE_W-1:0] LAST_CRYSTAL_MODE = 3'd2;

  function automatic logic osc_needs_startup(input logic [OSC_MODE_W-1:0] mode);
    return (mode <= LAST_CRYSTAL_MODE);
  endfunction

endpackage

// File: rtl/pwrup_stage_cnt.sv
module pwrup_stage_cnt #(
  parameter int LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic inc,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = en && inc && (cnt == LAST);

endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
  import pwrup_rst_pkg::*;
#(
  parameter int MODE_W = OSC_MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              mclr_n_i,
  input  logic              wdt_rst_i,
  input  logic [MODE_W-1:0] osc_mode_i,
  input  logic              pwrt_dis_i,
  input  logic              pwrt_done,
  input  logic              ost_done,
  output seq_state_e        state,
  output logic              core_rst_o
);
  seq_state_e nxt;
  logic       crystal;

  assign crystal = osc_needs_startup(osc_mode_i);

  always_comb begin
    nxt = state;
    if (restart) begin
      nxt = ST_POR;
    end else begin
      unique case (state)
        ST_POR: begin
          if (!pwrt_dis_i)  nxt = ST_PWRT;
          else if (crystal) nxt = ST_OST;
          else              nxt = ST_RUN;
        end
        ST_PWRT: begin
          if (pwrt_done) nxt = crystal ? ST_OST : ST_RUN;
        end
        ST_OST: begin
          if (ost_done) nxt = ST_RUN;
        end
        default: nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_POR;
      core_rst_o <= 1'b1;
    end else begin
      state      <= nxt;
      core_rst_o <= !((nxt == ST_RUN) && mclr_n_i && !wdt_rst_i);
    end
  end

endmodule

// File: rtl/pwrup_cause_reg.sv
module pwrup_cause_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_evt,
  input  logic       bor_evt,
  input  logic       sw_wr_i,
  input  logic [1:0] sw_wdata_i,
  output logic [1:0] cause_o
);
  logic pon_flag;
  logic bo_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      pon_flag <= 1'b0;
      bo_flag  <= 1'b0;
    end else begin
      if (por_evt)      pon_flag <= 1'b0;
      else if (sw_wr_i) pon_flag <= sw_wdata_i[1];
      if (bor_evt)      bo_flag  <= 1'b0;
      else if (sw_wr_i) bo_flag  <= sw_wdata_i[0];
    end
  end

  assign cause_o = {pon_flag, bo_flag};

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import pwrup_rst_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  por_i,
  input  logic                  bor_i,
  input  logic [1:0]            bor_en_i,
  input  logic                  mclr_n_i,
  input  logic                  wdt_rst_i,
  input  logic [OSC_MODE_W-1:0] osc_mode_i,
  input  logic                  pwrt_dis_i,
  input  logic                  slow_tick_i,
  input  logic                  sw_wr_i,
  input  logic [1:0]            sw_wdata_i,
  output logic [1:0]            state_o,
  output logic                  core_rst_o,
  output logic [1:0]            cause_o
);
  seq_state_e state;
  logic       bor_evt;
  logic       restart;
  logic       pwrt_done;
  logic       ost_done;

  assign bor_evt = bor_i && (bor_en_i != 2'b00);
  assign restart = por_i || bor_evt;

  pwrup_stage_cnt #(.LEN(PWRT_TICKS)) u_pwrt_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (state == ST_PWRT),
    .inc  (slow_tick_i),
    .done (pwrt_done)
  );

  pwrup_stage_cnt #(.LEN(OST_CYCLES)) u_ost_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (state == ST_OST),
    .inc  (1'b1),
    .done (ost_done)
  );

  pwrup_seq_fsm #(.MODE_W(OSC_MODE_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .mclr_n_i   (mclr_n_i),
    .wdt_rst_i  (wdt_rst_i),
    .osc_mode_i (osc_mode_i),
    .pwrt_dis_i (pwrt_dis_i),
    .pwrt_done  (pwrt_done),
    .ost_done   (ost_done),
    .state      (state),
    .core_rst_o (core_rst_o)
  );

  pwrup_cause_reg u_cause (
    .clk        (clk),
    .rst        (rst),
    .por_evt    (por_i),
    .bor_evt    (bor_evt),
    .sw_wr_i    (sw_wr_i),
    .sw_wdata_i (sw_wdata_i),
    .cause_o    (cause_o)
  );

  assign state_o = state;

endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_i,
  input logic       bor_i,
  input logic [1:0] bor_en_i,
  input logic       mclr_n_i,
  input logic       wdt_rst_i,
  input logic [2:0] osc_mode_i,
  input logic       pwrt_dis_i,
  input logic [1:0] state_o,
  input logic       core_rst_o,
  input logic [1:0] cause_o
);
  logic restart_c;
  logic crystal_c;

  assign restart_c = por_i || (bor_i && (bor_en_i != 2'b00));
  assign crystal_c = (osc_mode_i < 3'd3);

  a_r2_release_only_in_run: assert property (@(posedge clk) disable iff (rst)
    !core_rst_o |-> (state_o == 2'd3));

  a_r3_por_holds: assert property (@(posedge clk) disable iff (rst)
    por_i |=> (state_o == 2'd0));

  a_r4_timer_entered: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0) && !restart_c && !pwrt_dis_i |=> (state_o == 2'd1));

  a_r5_no_startup_noncrystal: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd2) && !crystal_c |=> (state_o != 2'd2));

  a_r7_pin_holds: assert property (@(posedge clk) disable iff (rst)
    !mclr_n_i |=> core_rst_o);

  a_r8_wdt_no_rerun: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_i && (state_o == 2'd3) && !restart_c |=> core_rst_o && (state_o == 2'd3));

  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    restart_c |=> (state_o == 2'd0));

  a_r10_pon_flag_clear: assert property (@(posedge clk) disable iff (rst)
    por_i |=> !cause_o[1]);

  a_r11_bo_flag_clear: assert property (@(posedge clk) disable iff (rst)
    bor_i && (bor_en_i != 2'b00) |=> !cause_o[0]);

endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .por_i      (por_i),
  .bor_i      (bor_i),
  .bor_en_i   (bor_en_i),
  .mclr_n_i   (mclr_n_i),
  .wdt_rst_i  (wdt_rst_i),
  .osc_mode_i (osc_mode_i),
  .pwrt_dis_i (pwrt_dis_i),
  .state_o    (state_o),
  .core_rst_o (core_rst_o),
  .cause_o    (cause_o)
);

// File: tb/pwrup_rst_seq_tb.sv
`timescale 1ns/1ps
module pwrup_rst_seq_tb;
  localparam int PT   = 5;
  localparam int OSTC = 16;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_i = 1'b1;
  logic       bor_i = 1'b0;
  logic [1:0] bor_en_i = 2'b00;
  logic       mclr_n_i = 1'b1;
  logic       wdt_rst_i = 1'b0;
  logic [2:0] osc_mode_i = 3'd0;
  logic       pwrt_dis_i = 1'b0;
  logic       slow_tick_i = 1'b0;
  logic       sw_wr_i = 1'b0;
  logic [1:0] sw_wdata_i = 2'b00;
  logic [1:0] state_o;
  logic       core_rst_o;
  logic [1:0] cause_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwrup_rst_seq #(.PWRT_TICKS(PT), .OST_CYCLES(OSTC)) u_dut (
    .clk(clk), .rst(rst), .por_i(por_i), .bor_i(bor_i), .bor_en_i(bor_en_i),
    .mclr_n_i(mclr_n_i), .wdt_rst_i(wdt_rst_i), .osc_mode_i(osc_mode_i),
    .pwrt_dis_i(pwrt_dis_i), .slow_tick_i(slow_tick_i), .sw_wr_i(sw_wr_i),
    .sw_wdata_i(sw_wdata_i), .state_o(state_o), .core_rst_o(core_rst_o),
    .cause_o(cause_o)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Power-on pulse, then release and count edges to the expected run point.
  task automatic run_seq(input logic [2:0] mode, input logic dis);
    int rel;
    int first;
    bit crystal;
    crystal = (mode < 3'd3);
    por_i = 1'b1;
    repeat (3) cyc();
    chk("R3 state held during power-on", state_o, 0);
    chk("R2 core reset during power-on", core_rst_o, 1);
    por_i = 1'b0;
    osc_mode_i = mode;
    pwrt_dis_i = dis;
    rel = (dis ? 1 : PT * TDIV) + (crystal ? OSTC : 0);
    first = !dis ? 1 : (crystal ? 2 : 3);
    for (int n = 1; n <= rel; n++) begin
      slow_tick_i = ((n % TDIV) == 0);
      cyc();
      if (n == 1) chk("R4/R5 first stage after release", state_o, first);
      if (!dis && crystal && n == PT * TDIV) chk("R5 start-up follows timer", state_o, 2);
      if (n == rel - 1) begin
        chk("R4/R5 not yet running", state_o, first == 3 ? 3 : ((!dis && !crystal) ? 1 : 2));
        chk("R2 core reset before release", core_rst_o, 1);
      end
      if (n == rel) begin
        chk(dis && mode == 3'd3 ? "R6 no timeout release" : "R4/R5 release edge", state_o, 3);
        chk("R2 core reset released", core_rst_o, 0);
      end
    end
    slow_tick_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) cyc();
    chk("R1 reset state", state_o, 0);
    chk("R1 reset core", core_rst_o, 1);
    chk("R1 reset cause", cause_o, 0);
    rst = 1'b0;

    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 2; d++) begin
        run_seq(3'(m), 1'(d));
      end
    end
    chk("R10 power-on flag cleared", cause_o[1], 0);

    sw_wr_i = 1'b1; sw_wdata_i = 2'b11;
    cyc();
    sw_wr_i = 1'b0;
    chk("R10/R11 software write", cause_o, 3);

    wdt_rst_i = 1'b1;
    cyc();
    wdt_rst_i = 1'b0;
    chk("R8 watchdog holds core", core_rst_o, 1);
    chk("R8 watchdog keeps state", state_o, 3);
    cyc();
    chk("R8 watchdog hold ends", core_rst_o, 0);
    chk("R10 watchdog leaves flags", cause_o, 3);

    mclr_n_i = 1'b0;
    cyc();
    chk("R7 pin low holds core", core_rst_o, 1);
    chk("R10 pin reset leaves flags", cause_o, 3);
    por_i = 1'b1;
    cyc();
    por_i = 1'b0; osc_mode_i = 3'd3; pwrt_dis_i = 1'b1;
    cyc();
    chk("R7 sequence runs with pin low", state_o, 3);
    chk("R7 core held with pin low", core_rst_o, 1);
    repeat (5) cyc();
    mclr_n_i = 1'b1;
    cyc();
    chk("R7 immediate start on pin rise", core_rst_o, 0);
    chk("R11 power-on leaves brown-out flag", cause_o, 1);

    bor_en_i = 2'b00; bor_i = 1'b1;
    cyc();
    chk("R9 brown-out ignored when disabled", state_o, 3);
    chk("R11 flag kept when disabled", cause_o[0], 1);
    bor_i = 1'b0;

    por_i = 1'b1;
    cyc();
    por_i = 1'b0; osc_mode_i = 3'd1; pwrt_dis_i = 1'b1;
    cyc();
    chk("R5 start-up without timer", state_o, 2);
    repeat (3) cyc();
    bor_en_i = 2'b01; bor_i = 1'b1; sw_wr_i = 1'b1; sw_wdata_i = 2'b11;
    cyc();
    bor_i = 1'b0; sw_wr_i = 1'b0;
    chk("R9 brown-out restarts", state_o, 0);
    chk("R11 clear beats write", cause_o[0], 0);
    chk("R10 write sets power-on flag", cause_o[1], 1);
    cyc();
    chk("R9 sequence reruns", state_o, 2);
    repeat (OSTC - 1) cyc();
    chk("R5 start-up length", state_o, 2);
    cyc();
    chk("R5 start-up ends", state_o, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule